// File: doc/BRIEF.md
# Rounding Sequential Q-Format Divider

This block divides one signed 16-bit fixed-point value by another and returns a 16-bit quotient in the same fixed-point format. The format carries `FRAC_W` fraction bits, from 0 to 15. Before dividing, the dividend is sign-extended to 32 bits and scaled up by 2^FRAC_W, so the quotient keeps the binary point in the same place. A bias of half the divisor is then applied so that a truncating divide rounds to the nearest value. The bias is added when the scaled dividend and the divisor have the same sign and subtracted when they differ, which sends exact halfway cases away from zero.

A request is a one-cycle `start` pulse with both operands present. The block accepts it only while `busy` is low. It then works out one quotient bit per clock with a restoring shift-subtract loop on magnitudes and applies the sign at the end. When the result is ready, `done` pulses for one cycle. The quotient and the zero-divisor flag stay on the outputs until the next request is accepted. The quotient is not saturated: it is the low 16 bits of the 32-bit truncated quotient.

Top module: `qdiv_round_seq`

## Requirements
- R1: The dividend is sign-extended to 32 bits and shifted left by `FRAC_W` before dividing, so the quotient has `FRAC_W` fraction bits (with `FRAC_W`=8, 0x0300 / 0x0200 gives 0x0180).
- R2: When the scaled dividend and the divisor have the same sign, the divisor divided by two (truncated toward zero) is added to the scaled dividend before the divide.
- R3: When their signs differ, that half-divisor is subtracted instead, so a result lying exactly halfway between two codes rounds away from zero (0xFFFF / 0x0200 gives 0xFFFF).
- R4: The biased value is divided with truncation toward zero, and `quotient` is the low 16 bits of the 32-bit result with no saturation (0x0100 / 0x0001 gives 0x0000).
- R5: Operands are two's complement, and the sign of each is its most significant bit (bit 15 of each operand, bit 31 of the scaled dividend).
- R6: A divisor of zero sets `div_by_zero` to 1 and forces `quotient` to 0x7FFF when dividend bit 15 is 0 and to 0x8000 when it is 1. For any other divisor, `div_by_zero` is 0.
- R7: `start` is accepted only when `busy` is low. A `start` while `busy` is high changes neither the running result nor its timing, and it does not queue a second result.
- R8: `busy` rises after the accepting edge and stays high for 32 cycles. `done` is high during the cycle after the 32nd rising edge following the accepting edge, and `busy` is low in that cycle.
- R9: `done` is high for exactly one cycle per accepted request.
- R10: From `done` until the next accepted `start`, `quotient` and `div_by_zero` hold their values whatever the operand inputs do.
- R11: An asynchronous active-low reset, applied at any time, drives `busy`, `done` and `div_by_zero` to 0 and `quotient` to 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, taken when busy is low |
| dividend | input | 16 | Signed Q-format numerator |
| divisor | input | 16 | Signed Q-format denominator |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse: result valid |
| quotient | output | 16 | Rounded Q-format quotient, held after done |
| div_by_zero | output | 1 | Divisor was zero, held with the quotient |

## Verification
The case that is hardest to reach from the ports is a rounding decision that falls exactly on a halfway point with opposite operand signs. There the bias direction alone decides the result, and only a narrow set of operand pairs lands on it. The stimulus table is therefore built around hand-derived halfway pairs, such as one LSB over two and thirds in all four sign combinations, together with divisors of plus and minus one LSB and the most negative code. A second `start` injected in the middle of a running division, and a reset asserted while busy, cover the handshake corners. A pseudo-random sweep checked against an arithmetic model covers the rest.

// File: rtl/qdiv_pkg.sv
package qdiv_pkg;

  localparam int QD_W     = 16;
  localparam int QD_WIDE  = 2 * QD_W;
  localparam int QD_CNT_W = $clog2(QD_WIDE);

  typedef logic [QD_W-1:0]     word_t;
  typedef logic [QD_WIDE-1:0]  wide_t;
  typedef logic [QD_CNT_W-1:0] cnt_t;

  // operands prepared for the magnitude loop
  typedef struct packed {
    wide_t num_mag;
    word_t den_mag;
    logic  q_neg;
    logic  den_zero;
    logic  a_neg;
  } job_t;

  // partial remainder and shifting numerator/quotient
  typedef struct packed {
    word_t rem;
    wide_t num;
  } step_t;

  function automatic wide_t sext_word(input word_t v);
    return {{QD_W{v[QD_W-1]}}, v};
  endfunction

  // sign-extend and move the binary point up by frac bits
  function automatic wide_t prescale(input word_t a, input int unsigned frac);
    wide_t x;
    x = sext_word(a);
    return x << frac;
  endfunction

  // divisor / 2, truncated toward zero
  function automatic wide_t half_toward_zero(input word_t b);
    wide_t bw;
    bw = sext_word(b);
    if (bw[QD_WIDE-1]) return -((-bw) >> 1);
    return bw >> 1;
  endfunction

  // round-to-nearest bias: add when signs agree, subtract otherwise
  function automatic wide_t apply_bias(input wide_t s, input word_t b);
    wide_t h;
    h = half_toward_zero(b);
    if (s[QD_WIDE-1] == b[QD_W-1]) return s + h;
    return s - h;
  endfunction

  function automatic wide_t mag_wide(input wide_t x);
    return x[QD_WIDE-1] ? -x : x;
  endfunction

  function automatic word_t mag_word(input word_t x);
    return x[QD_W-1] ? -x : x;
  endfunction

  // one restoring iteration: shift in the next numerator bit, try to subtract
  function automatic step_t div_step(input step_t s, input word_t den);
    logic [QD_W:0] sh;
    logic [QD_W:0] diff;
    step_t r;
    sh       = {s.rem, s.num[QD_WIDE-1]};
    diff     = sh - {1'b0, den};
    r.num    = {s.num[QD_WIDE-2:0], 1'b0};
    if (sh >= {1'b0, den}) begin
      r.rem    = diff[QD_W-1:0];
      r.num[0] = 1'b1;
    end else begin
      r.rem    = sh[QD_W-1:0];
    end
    return r;
  endfunction

  // sign fix-up, wrap to word, zero-divisor override
  function automatic word_t finish_quotient(input wide_t qmag, input logic neg,
                                            input logic zero, input logic a_neg);
    wide_t q;
    if (zero) return a_neg ? {1'b1, {(QD_W-1){1'b0}}} : {1'b0, {(QD_W-1){1'b1}}};
    q = neg ? -qmag : qmag;
    return q[QD_W-1:0];
  endfunction

endpackage

// File: rtl/qdiv_prep.sv
module qdiv_prep
  import qdiv_pkg::*;
#(
  parameter int FRAC_W = 8
) (
  input  logic [QD_W-1:0] dividend,
  input  logic [QD_W-1:0] divisor,
  output job_t            job,
  output logic            bias_added
);

  if (FRAC_W < 0 || FRAC_W >= QD_W) begin : g_frac_range
    $error("qdiv_prep: FRAC_W out of range");
  end

  wide_t scaled;
  wide_t biased;

  always_comb begin
    scaled       = prescale(dividend, FRAC_W);
    biased       = apply_bias(scaled, divisor);
    bias_added   = (scaled[QD_WIDE-1] == divisor[QD_W-1]);
    job.num_mag  = mag_wide(biased);
    job.den_mag  = mag_word(divisor);
    job.q_neg    = biased[QD_WIDE-1] ^ divisor[QD_W-1];
    job.den_zero = (divisor == '0);
    job.a_neg    = dividend[QD_W-1];
  end

endmodule

// File: rtl/qdiv_iter.sv
module qdiv_iter
  import qdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [QD_WIDE-1:0] num_in,
  input  logic [QD_W-1:0]    den_in,
  output logic               busy,
  output logic               done,
  output logic               last_step,
  output logic [QD_WIDE-1:0] quo_mag
);

  localparam cnt_t LAST_CNT = cnt_t'(QD_WIDE - 1);

  step_t st_q;
  step_t st_next;
  word_t den_q;
  cnt_t  cnt_q;

  assign st_next   = div_step(st_q, den_q);
  assign last_step = busy && (cnt_q == LAST_CNT);
  assign quo_mag   = st_q.num;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt_q <= '0;
      den_q <= '0;
      st_q  <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy     <= 1'b1;
        cnt_q    <= '0;
        den_q    <= den_in;
        st_q.rem <= '0;
        st_q.num <= num_in;
      end else if (busy) begin
        st_q  <= st_next;
        cnt_q <= cnt_q + 1'b1;
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/qdiv_fix.sv
module qdiv_fix
  import qdiv_pkg::*;
(
  input  logic [QD_WIDE-1:0] quo_mag,
  input  logic               q_neg,
  input  logic               den_zero,
  input  logic               a_neg,
  output logic [QD_W-1:0]    quotient
);

  always_comb quotient = finish_quotient(quo_mag, q_neg, den_zero, a_neg);

endmodule

// File: rtl/qdiv_round_seq.sv
module qdiv_round_seq
  import qdiv_pkg::*;
#(
  parameter int FRAC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [QD_W-1:0] dividend,
  input  logic [QD_W-1:0] divisor,
  output logic            busy,
  output logic            done,
  output logic [QD_W-1:0] quotient,
  output logic            div_by_zero
);

  logic  accept;
  logic  last_step;
  logic  bias_added;
  job_t  job;
  wide_t quo_mag;
  logic  q_neg_q;
  logic  zero_q;
  logic  a_neg_q;

  assign accept = start & ~busy;

  qdiv_prep #(.FRAC_W(FRAC_W)) u_prep (
    .dividend   (dividend),
    .divisor    (divisor),
    .job        (job),
    .bias_added (bias_added)
  );

  qdiv_iter u_iter (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .num_in    (job.num_mag),
    .den_in    (job.den_mag),
    .busy      (busy),
    .done      (done),
    .last_step (last_step),
    .quo_mag   (quo_mag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_neg_q <= 1'b0;
      zero_q  <= 1'b0;
      a_neg_q <= 1'b0;
    end else if (accept) begin
      q_neg_q <= job.q_neg;
      zero_q  <= job.den_zero;
      a_neg_q <= job.a_neg;
    end
  end

  qdiv_fix u_fix (
    .quo_mag  (quo_mag),
    .q_neg    (q_neg_q),
    .den_zero (zero_q),
    .a_neg    (a_neg_q),
    .quotient (quotient)
  );

  assign div_by_zero = zero_q;

endmodule

// File: rtl/qdiv_round_seq_chk.sv
module qdiv_round_seq_chk
  import qdiv_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            last_step,
  input logic [QD_W-1:0] quotient,
  input logic            div_by_zero
);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy);

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(quotient) && $stable(div_by_zero)));

  // R6
  zero_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (quotient == 16'h7FFF || quotient == 16'h8000));

endmodule

bind qdiv_round_seq qdiv_round_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .last_step   (last_step),
  .quotient    (quotient),
  .div_by_zero (div_by_zero)
);

// File: tb/tb_qdiv_round_seq.sv
module tb_qdiv_round_seq;
  import qdiv_pkg::*;

  localparam int FRAC = 8;
  localparam int LAT  = QD_WIDE + 1;  // negedges from start negedge to done
  localparam int NVEC = 23;

  // {dividend, divisor, expected quotient, expected div_by_zero}, FRAC = 8
  localparam logic [48:0] VEC [NVEC] = '{
    {16'h0100, 16'h0200, 16'h0080, 1'b0},
    {16'h0300, 16'h0200, 16'h0180, 1'b0},
    {16'hFD00, 16'h0200, 16'hFE80, 1'b0},
    {16'h0100, 16'h0300, 16'h0055, 1'b0},
    {16'h0200, 16'h0300, 16'h00AB, 1'b0},
    {16'hFE00, 16'h0300, 16'hFF55, 1'b0},
    {16'h0200, 16'hFD00, 16'hFF55, 1'b0},
    {16'hFE00, 16'hFD00, 16'h00AB, 1'b0},
    {16'h0001, 16'h0200, 16'h0001, 1'b0},
    {16'hFFFF, 16'h0200, 16'hFFFF, 1'b0},
    {16'h0040, 16'h0001, 16'h4000, 1'b0},
    {16'h0040, 16'hFFFF, 16'hC000, 1'b0},
    {16'h0100, 16'h0001, 16'h0000, 1'b0},
    {16'h1234, 16'h0100, 16'h1234, 1'b0},
    {16'h1234, 16'hFF00, 16'hEDCC, 1'b0},
    {16'h8000, 16'h8000, 16'h0100, 1'b0},
    {16'h7FFF, 16'h8000, 16'hFF00, 1'b0},
    {16'h0000, 16'hFC00, 16'h0000, 1'b0},
    {16'h0001, 16'h0300, 16'h0000, 1'b0},
    {16'h0500, 16'h0000, 16'h7FFF, 1'b1},
    {16'hF000, 16'h0000, 16'h8000, 1'b1},
    {16'h0000, 16'h0000, 16'h7FFF, 1'b1},
    {16'hFFFF, 16'h0001, 16'hFF00, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] dividend = '0;
  logic [15:0] divisor = '0;
  logic        busy;
  logic        done;
  logic [15:0] quotient;
  logic        div_by_zero;

  int checks = 0;
  int errors = 0;
  bit ended  = 1'b0;

  always #5 clk = ~clk;

  qdiv_round_seq #(.FRAC_W(FRAC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .div_by_zero(div_by_zero)
  );

  // arithmetic model: biased 64-bit integer division, truncating
  function automatic logic [15:0] model_q(input logic [15:0] a, input logic [15:0] b);
    longint sa, sb, s, h, q;
    logic [63:0] qv;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (sb == 0) return a[15] ? 16'h8000 : 16'h7FFF;
    s = sa * (64'sd1 <<< FRAC);
    h = sb / 2;
    if ((s < 0) == (sb < 0)) s = s + h;
    else s = s - h;
    q  = s / sb;
    qv = q;
    return qv[15:0];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic run_div(input logic [15:0] a, input logic [15:0] b,
                         output logic [15:0] q, output logic dz, output int lat);
    @(negedge clk);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat   = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    q  = quotient;
    dz = div_by_zero;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    logic [15:0] q;
    logic        dz;
    int          lat;
    logic [31:0] rng;
    int          ndone;

    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 busy at reset", busy, 0);
    check("R11 done at reset", done, 0);
    check("R11 quotient at reset", quotient, 0);
    check("R11 div_by_zero at reset", div_by_zero, 0);
    rst_n = 1'b1;

    // table walk: R1 R2 R3 R4 R5 R6 values, R8 latency, R9 single pulse
    for (int i = 0; i < NVEC; i++) begin
      run_div(VEC[i][48:33], VEC[i][32:17], q, dz, lat);
      check($sformatf("R1 R2 R3 R4 R5 vector %0d quotient", i), q, VEC[i][16:1]);
      check($sformatf("R4 vector %0d model", i), q, model_q(VEC[i][48:33], VEC[i][32:17]));
      check($sformatf("R6 vector %0d div_by_zero", i), dz, VEC[i][0]);
      check($sformatf("R8 vector %0d latency", i), lat, LAT);
      check($sformatf("R8 vector %0d busy low at done", i), busy, 0);
      @(negedge clk);
      check($sformatf("R9 vector %0d done drops", i), done, 0);
    end

    // R2: same-sign halfway, bias added (0.5 LSB rounds up)
    run_div(16'h0001, 16'h0200, q, dz, lat);
    check("R2 halfway same sign", q, 16'h0001);
    // R3: opposite-sign halfway rounds away from zero
    run_div(16'h0001, 16'hFE00, q, dz, lat);
    check("R3 halfway opposite sign", q, 16'hFFFF);
    // R5: most negative dividend by +1.0
    run_div(16'h8000, 16'h0100, q, dz, lat);
    check("R5 most negative by one", q, 16'h8000);

    // R10: result held while operands move without start
    run_div(16'h0300, 16'h0200, q, dz, lat);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      dividend = 16'h5A5A ^ 16'(k);
      divisor  = 16'h0000;
    end
    check("R10 quotient held", quotient, 16'h0180);
    check("R10 div_by_zero held", div_by_zero, 0);

    // R7: second start while busy is ignored
    @(negedge clk);
    dividend = 16'h0300;
    divisor  = 16'h0200;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat   = 1;
    repeat (4) begin
      @(negedge clk);
      lat++;
    end
    dividend = 16'hFD00;
    divisor  = 16'h0000;
    start    = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check("R7 latency unchanged", lat, LAT);
    check("R7 quotient from first request", quotient, 16'h0180);
    check("R7 div_by_zero from first request", div_by_zero, 0);
    ndone = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) ndone++;
    end
    check("R7 no queued result", ndone, 0);
    check("R7 idle after ignored start", busy, 0);

    // R11: reset in the middle of a division
    @(negedge clk);
    dividend = 16'hF000;
    divisor  = 16'h0000;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 busy after mid-run reset", busy, 0);
    check("R11 done after mid-run reset", done, 0);
    check("R11 quotient after mid-run reset", quotient, 0);
    check("R11 div_by_zero after mid-run reset", div_by_zero, 0);
    rst_n = 1'b1;

    // R4 sweep against the model
    rng = 32'h1ACE_B00C;
    for (int i = 0; i < 150; i++) begin
      logic [15:0] a, b;
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      a = rng[15:0];
      b = rng[31:16];
      if (i % 3 == 0) b = {{12{rng[19]}}, rng[19:16]};
      run_div(a, b, q, dz, lat);
      check($sformatf("R4 sweep %0d a=%h b=%h", i, a, b), q, model_q(a, b));
      check($sformatf("R6 sweep %0d flag", i), dz, (b == 16'h0000));
    end

    summary();
  end

endmodule